// File: doc/BRIEF.md
# Timer interrupt flag and mask unit

This block keeps the pending-interrupt flags and the per-source interrupt enables for one 8-bit timer. The timer has three event sources: counter overflow, compare match A and compare match B. The timer core sends each event as a one-cycle pulse. The block catches each pulse in a sticky flag. A flag stays set until software clears it or until the CPU enters that source's interrupt vector.

A byte-wide register port selects one of two registers with a single select bit. The port reads either register, writes the enable register, and clears flags when ones are written to the flag register. A per-source acknowledge input clears a flag in hardware when its vector is taken. Each source has its own request line. A request is the AND of the global interrupt enable, that source's enable bit and that source's flag. Counting, comparing, vector priority and the CPU all sit outside the block.

Top module: `tif_unit`

## Requirements
- R1: While `rst_n` is low, both registers read 0x00 and every `irq_req` bit is 0. The reset is applied asynchronously and released on a clock edge.
- R2: The bit positions are the same in both registers: bit 0 is overflow, bit 1 is compare match A, bit 2 is compare match B. `bus_sel` = 0 addresses the enable register and `bus_sel` = 1 addresses the flag register.
- R3: A one on `evt_pulse[i]` at a clock edge sets flag i, whatever the value of enable bit i. The flag reads as one from that edge onward.
- R4: A write to the flag register clears, at the clock edge, every flag whose data bit is one. Flags whose data bit is zero keep their value.
- R5: A one on `irq_ack[i]` at a clock edge clears flag i at that edge.
- R6: If a set event and a clear (a write-one, an acknowledge, or both) reach the same flag at the same edge, the flag ends up set.
- R7: `irq_req[i]` is high in exactly those cycles where `glb_ie`, enable bit i and flag i are all one. It follows `glb_ie` within the same cycle, with no register delay.
- R8: Bits 7 to 3 of both registers always read zero. Writing to those bits changes nothing.
- R9: A write to the enable register loads bits 2 to 0 at the clock edge. The read port returns the new value in the next cycle. Reads are combinational and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_pulse | input | 3 | One-cycle event pulses from the timer core (bit 0 overflow, 1 compare A, 2 compare B) |
| irq_ack | input | 3 | Vector-entry acknowledge per source; clears that flag |
| glb_ie | input | 1 | Global interrupt enable |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 enable, 1 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_req | output | 3 | Interrupt request per source |

## Verification
Results are due at two different times:
- **Next cycle.** Every flag and enable update (event set, write-one clear, acknowledge, enable write) takes effect at the edge on which its input is present. It can therefore be read on `bus_rdata` in the cycle that follows.
- **Same cycle.** `irq_req` and `bus_rdata` respond to `glb_ie` and `bus_sel` without delay.

The bench drives every input just after the falling edge. It moves its model forward at the rising edge, and it compares both outputs a short time after the next falling edge. At that point the registered state and the current inputs are both settled. Directed cases read the flag register one cycle after the stimulus. Same-cycle conflicts are included so that the set-wins rule is seen on the port.

// File: rtl/tif_pkg.sv
package tif_pkg;

  // Register selected by the one-bit select line of the register port
  typedef enum logic {
    REG_ENABLE = 1'b0,
    REG_FLAG   = 1'b1
  } tif_reg_e;

  // Source bit positions, shared by the enable and flag registers
  localparam int unsigned SRC_OVF  = 0;
  localparam int unsigned SRC_CMPA = 1;
  localparam int unsigned SRC_CMPB = 2;

endpackage

// File: rtl/tif_flag_bank.sv
module tif_flag_bank #(
  parameter int unsigned SRC_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_i,
  input  logic             sw_clr_en_i,
  input  logic [SRC_N-1:0] sw_clr_mask_i,
  input  logic [SRC_N-1:0] hw_clr_i,
  output logic [SRC_N-1:0] flag_o
);

  for (genvar g = 0; g < SRC_N; g++) begin : g_cell
    logic clr_req;
    logic upd_en;
    logic flag_d;
    logic flag_q;

    // next-state: a set event overrides any clear in the same cycle
    always_comb begin
      clr_req = (sw_clr_en_i & sw_clr_mask_i[g]) | hw_clr_i[g];
      upd_en  = set_i[g] | clr_req;
      flag_d  = set_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (upd_en) begin
        flag_q <= flag_d;
      end
    end

    assign flag_o[g] = flag_q;
  end

endmodule

// File: rtl/tif_enable_reg.sv
module tif_enable_reg #(
  parameter int unsigned SRC_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SRC_N-1:0] data_i,
  output logic [SRC_N-1:0] en_o
);

  logic [SRC_N-1:0] en_d;
  logic [SRC_N-1:0] en_q;

  always_comb begin
    en_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (load_i) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/tif_read_mux.sv
module tif_read_mux #(
  parameter int unsigned SRC_N  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  tif_pkg::tif_reg_e sel_i,
  input  logic [SRC_N-1:0]  en_i,
  input  logic [SRC_N-1:0]  flag_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [SRC_N-1:0] live;

  always_comb begin
    live = (sel_i == tif_pkg::REG_FLAG) ? flag_i : en_i;
  end

  assign rdata_o[SRC_N-1:0] = live;

  // reserved upper bits are tied to zero
  if (DATA_W > SRC_N) begin : g_pad
    assign rdata_o[DATA_W-1:SRC_N] = '0;
  end

endmodule

// File: rtl/tif_irq_gate.sv
module tif_irq_gate #(
  parameter int unsigned SRC_N = 3
) (
  input  logic             gie_i,
  input  logic [SRC_N-1:0] en_i,
  input  logic [SRC_N-1:0] flag_i,
  output logic [SRC_N-1:0] req_o
);

  for (genvar g = 0; g < SRC_N; g++) begin : g_req
    assign req_o[g] = gie_i & en_i[g] & flag_i[g];
  end

endmodule

// File: rtl/tif_unit.sv
module tif_unit #(
  parameter int unsigned SRC_N  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_pulse,
  input  logic [SRC_N-1:0]  irq_ack,
  input  logic              glb_ie,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SRC_N-1:0]  irq_req
);

  localparam int unsigned PAD_W = (DATA_W > SRC_N) ? (DATA_W - SRC_N) : 1;

  tif_pkg::tif_reg_e sel;
  logic              wr_en_reg;
  logic              wr_flag_reg;
  logic [SRC_N-1:0]  wdata_src;
  logic [SRC_N-1:0]  en_q;
  logic [SRC_N-1:0]  flag_q;
  logic [PAD_W-1:0]  unused_wdata_hi;

  always_comb begin
    sel         = tif_pkg::tif_reg_e'(bus_sel);
    wr_en_reg   = bus_wr & (sel == tif_pkg::REG_ENABLE);
    wr_flag_reg = bus_wr & (sel == tif_pkg::REG_FLAG);
    wdata_src   = bus_wdata[SRC_N-1:0];
  end

  // write data above the source bits has no storage behind it
  if (DATA_W > SRC_N) begin : g_hi
    assign unused_wdata_hi = bus_wdata[DATA_W-1:SRC_N];
  end else begin : g_nohi
    assign unused_wdata_hi = '0;
  end

  tif_enable_reg #(.SRC_N(SRC_N)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wr_en_reg),
    .data_i (wdata_src),
    .en_o   (en_q)
  );

  tif_flag_bank #(.SRC_N(SRC_N)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_i         (evt_pulse),
    .sw_clr_en_i   (wr_flag_reg),
    .sw_clr_mask_i (wdata_src),
    .hw_clr_i      (irq_ack),
    .flag_o        (flag_q)
  );

  tif_read_mux #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_rd (
    .sel_i   (sel),
    .en_i    (en_q),
    .flag_i  (flag_q),
    .rdata_o (bus_rdata)
  );

  tif_irq_gate #(.SRC_N(SRC_N)) u_irq (
    .gie_i  (glb_ie),
    .en_i   (en_q),
    .flag_i (flag_q),
    .req_o  (irq_req)
  );

endmodule

// File: rtl/tif_unit_chk.sv
module tif_unit_chk #(
  parameter int unsigned SRC_N  = 3,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  evt_pulse,
  input logic [SRC_N-1:0]  irq_ack,
  input logic              glb_ie,
  input logic              bus_wr,
  input logic              bus_sel,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [SRC_N-1:0]  irq_req,
  input logic [SRC_N-1:0]  en_q,
  input logic [SRC_N-1:0]  flag_q
);

  // R3
  set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R4
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && evt_pulse == '0 && irq_ack == '0)
      |=> ((flag_q & $past(bus_wdata[SRC_N-1:0])) == '0));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_sel) && evt_pulse == '0 && irq_ack == '0) |=> $stable(flag_q));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ack & ~evt_pulse) != '0) |=> ((flag_q & $past(irq_ack & ~evt_pulse)) == '0));

  // R7
  req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |-> glb_ie);

  // R7
  req_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~(flag_q & en_q)) == '0));

  // R9
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel) |=> (en_q == $past(bus_wdata[SRC_N-1:0])));

  if (DATA_W > SRC_N) begin : g_rsv
    // R8
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[DATA_W-1:SRC_N] == '0));
  end

endmodule

bind tif_unit tif_unit_chk #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_pulse (evt_pulse),
  .irq_ack   (irq_ack),
  .glb_ie    (glb_ie),
  .bus_wr    (bus_wr),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_req   (irq_req),
  .en_q      (en_q),
  .flag_q    (flag_q)
);

// File: tb/tif_unit_test.sv
`timescale 1ns/1ps
module tif_unit_test;

  logic       clk;
  logic       rst_n;
  logic [2:0] evt_pulse;
  logic [2:0] irq_ack;
  logic       glb_ie;
  logic       bus_wr;
  logic       bus_sel;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [2:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  bit [2:0] m_en   = '0;
  bit [2:0] m_flag = '0;

  tif_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .irq_ack(irq_ack),
    .glb_ie(glb_ie), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // model advances on the rising edge with the inputs present there
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en   = '0;
      m_flag = '0;
    end else begin
      bit [2:0] f;
      f = m_flag;
      if (bus_wr && bus_sel)  f = f & ~bus_wdata[2:0];
      f = f & ~irq_ack;
      f = f | evt_pulse;
      if (bus_wr && !bus_sel) m_en = bus_wdata[2:0];
      m_flag = f;
    end
  end

  // per-cycle comparison after the falling edge, inputs and state settled
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R2 R9 rdata vs model", bus_rdata, {5'b0, bus_sel ? m_flag : m_en});
      chk("R7 irq_req vs model", {5'b0, irq_req}, {5'b0, m_flag & m_en & {3{glb_ie}}});
    end
  end

  task automatic cyc(input logic [2:0] evt, input logic [2:0] ack, input logic wr,
                     input logic sel, input logic [7:0] wd, input logic gie);
    @(negedge clk);
    evt_pulse = evt;
    irq_ack   = ack;
    bus_wr    = wr;
    bus_sel   = sel;
    bus_wdata = wd;
    glb_ie    = gie;
    #3;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    evt_pulse = '0; irq_ack = '0; bus_wr = 0; bus_sel = 0; bus_wdata = '0; glb_ie = 1;
    // R1: reset state, even with events and enables being written
    cyc(3'b111, 3'b000, 1, 0, 8'hFF, 1);
    cyc(3'b000, 3'b000, 0, 0, 8'h00, 1);
    chk("R1 enable in reset", bus_rdata, 8'h00);
    chk("R1 irq in reset", {5'b0, irq_req}, 8'h00);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R1 flags in reset", bus_rdata, 8'h00);
    rst_n = 1'b1;

    // R9 and R8: enable write, reserved bits ignored
    cyc(3'b000, 3'b000, 1, 0, 8'hFF, 1);
    cyc(3'b000, 3'b000, 0, 0, 8'h00, 1);
    chk("R9 enable readback", bus_rdata, 8'h07);

    // R3: event sets flag while disabled
    cyc(3'b000, 3'b000, 1, 0, 8'h00, 1);
    cyc(3'b001, 3'b000, 0, 1, 8'h00, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R3 overflow flag set while disabled", bus_rdata, 8'h01);
    chk("R3 no request while disabled", {5'b0, irq_req}, 8'h00);

    // R2: compare A lands in bit 1
    cyc(3'b010, 3'b000, 0, 1, 8'h00, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R2 compare A at bit 1", bus_rdata, 8'h03);

    // R7: gating by global and per-source enable
    cyc(3'b000, 3'b000, 1, 0, 8'h07, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R7 requests with gie", {5'b0, irq_req}, 8'h03);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 0);
    chk("R7 requests without gie", {5'b0, irq_req}, 8'h00);

    // R4: writing zero keeps, writing one clears
    cyc(3'b000, 3'b000, 1, 1, 8'h00, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R4 write zero keeps flags", bus_rdata, 8'h03);
    cyc(3'b100, 3'b000, 0, 1, 8'h00, 1);
    cyc(3'b000, 3'b000, 1, 1, 8'h02, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R4 write one clears bit 1 only", bus_rdata, 8'h05);

    // R5: acknowledge clears
    cyc(3'b000, 3'b001, 0, 1, 8'h00, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R5 ack clears overflow flag", bus_rdata, 8'h04);

    // R6: set wins over simultaneous clears
    cyc(3'b100, 3'b000, 1, 1, 8'h04, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R6 set beats write-one", bus_rdata, 8'h04);
    cyc(3'b100, 3'b100, 1, 1, 8'h04, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R6 set beats ack and write", bus_rdata, 8'h04);
    cyc(3'b001, 3'b001, 0, 1, 8'h00, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R6 set beats ack", bus_rdata, 8'h05);

    // R8: reserved bits of writes have no effect
    cyc(3'b000, 3'b000, 1, 1, 8'hF8, 1);
    cyc(3'b000, 3'b000, 0, 1, 8'h00, 1);
    chk("R8 reserved flag write ignored", bus_rdata, 8'h05);
    cyc(3'b000, 3'b000, 1, 0, 8'hF8, 1);
    cyc(3'b000, 3'b000, 0, 0, 8'h00, 1);
    chk("R8 reserved enable write ignored", bus_rdata, 8'h00);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] e;
      logic [2:0] a;
      e = $urandom_range(0, 3) == 0 ? 3'($urandom) : 3'b000;
      a = $urandom_range(0, 3) == 0 ? 3'($urandom) : 3'b000;
      cyc(e, a, ($urandom_range(0, 3) == 0), 1'($urandom), 8'($urandom), 1'($urandom));
    end

    cyc(3'b000, 3'b000, 0, 0, 8'h00, 1);
    done = 1;
    finish_run();
  end

endmodule